// File: doc/BRIEF.md
# Per-Channel Window Comparator With Hysteresis and Event Qualification

This block watches a stream of conversion results, each tagged with the channel it belongs to. There are eight channels. Every channel holds its own high and low limit, a hysteresis amount, a required run length of consecutive violations, and a region select. When a valid result arrives and the comparator is globally enabled, the block compares the result with the limits of its channel. It applies hysteresis to any limit condition that is already active. It then counts consecutive violating samples. Once the run reaches the programmed length, it raises sticky high and low flags for that channel.

A per-channel region bit chooses the meaning of a violation. With the bit clear, the block reacts to results outside the band. With the bit set, it reacts to results inside the band. The flags are always recorded. A mask only decides which flagged channels drive the single combined alert output. The incoming result is 16 bits wide and may be a plain 12-bit code or a 16-bit averaged code. A mode input selects which 12 bits are compared.

Configuration is loaded one channel per write through a simple write strobe. Each flag bit is cleared by writing 1 to its clear strobe.

Top module: `win_cmp_top`

## Requirements
- R1: After reset every channel has high limit 0xFFF, low limit 0x000, hysteresis 0, run length 0 and region 0. Both flag vectors and `alert_o` are 0. With that configuration no result of any value sets a flag.
- R2: With region 0, a sample sets the high flag of its channel when the value is strictly above the high limit, and sets the low flag when the value is strictly below the low limit. A value equal to a limit sets neither flag.
- R3: With region 1, a sample whose value lies inside the band (low limit ≤ value ≤ high limit) sets both the high and the low flag of its channel. A value outside the band sets neither.
- R4: Once a high condition is active on a channel, later samples keep it active while the value is above (high limit − hysteresis), saturating at 0. Once a low condition is active, later samples keep it active while the value is below (low limit + hysteresis), saturating at 0xFFF. Hysteresis is 8 bits wide.
- R5: A flag is set only when the current sample makes the count of consecutive violating samples on that channel reach the run length N. N is 4 bits wide, and N = 0 acts as 1. Any non-violating sample on that channel resets the count to 0.
- R6: With `avg_i` = 1 the compared value is `res_i[15:4]`. With `avg_i` = 0 it is `res_i[11:0]`.
- R7: A sample presented while `cmp_en_i` = 0 has no effect on flags, hysteresis state or run counts.
- R8: Flags are sticky. Bit i of `clr_hi_i` or `clr_lo_i` clears bit i of the matching flag on the next edge. A set in the same cycle as a clear wins. Each flag changes on the clock edge that takes in its sample.
- R9: `alert_o` is 1 exactly when some channel i has a set high or low flag and `alert_mask_i[i]` = 1. Flags are set regardless of the mask.
- R10: A sample tagged with channel c (the value of `ch_i`) affects only the state and flags of channel c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Load configuration of channel `cfg_ch_i` |
| cfg_ch_i | input | 3 | Channel being configured |
| cfg_thr_hi_i | input | 12 | High limit to load |
| cfg_thr_lo_i | input | 12 | Low limit to load |
| cfg_hys_i | input | 8 | Hysteresis to load |
| cfg_evt_i | input | 4 | Consecutive-violation run length to load |
| cfg_region_i | input | 1 | Region select to load: 0 outside band, 1 inside band |
| cmp_en_i | input | 1 | Global comparator enable |
| avg_i | input | 1 | Result is a 16-bit averaged code |
| vld_i | input | 1 | Sample valid strobe |
| ch_i | input | 3 | Channel tag of the sample |
| res_i | input | 16 | Sample value |
| alert_mask_i | input | 8 | Channels allowed to drive `alert_o` |
| clr_hi_i | input | 8 | Write-1-to-clear strobes for the high flags |
| clr_lo_i | input | 8 | Write-1-to-clear strobes for the low flags |
| flag_hi_o | output | 8 | Sticky high flags |
| flag_lo_o | output | 8 | Sticky low flags |
| alert_o | output | 1 | Combined masked alert |

## Verification
The bench sweeps every 12-bit value against one outside-band channel and one inside-band channel, and compares each result with arithmetic limit checks. This exposes off-by-one limit comparisons, which would set flags at a value equal to a limit, and leakage into other channels. Directed runs cover the hysteresis release points on both sides; a design that ignored the active state would drop the flag too early. They also cover a run broken by one good sample; a counter that did not restart would fire early. Further runs cover the averaged bit slice, and a sample taken while disabled, which must leave no trace. They check that a set wins over a simultaneous clear, and that a flag stays set while masked out of the alert.

// File: rtl/wc_pkg.sv
package wc_pkg;
  parameter int unsigned WC_THR_W = 12;
  parameter int unsigned WC_HYS_W = 8;
  parameter int unsigned WC_CNT_W = 4;

  typedef struct packed {
    logic [WC_THR_W-1:0] thr_hi;
    logic [WC_THR_W-1:0] thr_lo;
    logic [WC_HYS_W-1:0] hys;
    logic [WC_CNT_W-1:0] evt;
    logic                region;
  } chan_cfg_t;
endpackage

// File: rtl/wc_cfg_bank.sv
module wc_cfg_bank
  import wc_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CH_W   = $clog2(NUM_CH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [CH_W-1:0]         ch_i,
  input  chan_cfg_t               wdata_i,
  output chan_cfg_t [NUM_CH-1:0]  cfg_o
);
  localparam chan_cfg_t CfgRst = '{
    thr_hi: '1, thr_lo: '0, hys: '0, evt: '0, region: 1'b0
  };

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    chan_cfg_t cfg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q <= CfgRst;
      else if (wr_i && ch_i == CH_W'(g)) cfg_q <= wdata_i;
    end
    assign cfg_o[g] = cfg_q;
  end
endmodule

// File: rtl/wc_chan.sv
module wc_chan
  import wc_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                smp_i,
  input  logic [WC_THR_W-1:0] data_i,
  input  chan_cfg_t           cfg_i,
  input  logic                clr_hi_i,
  input  logic                clr_lo_i,
  output logic                flag_hi_o,
  output logic                flag_lo_o
);
  localparam logic [WC_THR_W-1:0] ThrMax = '1;
  localparam logic [WC_CNT_W-1:0] CntMax = '1;

  logic                hi_act_q, lo_act_q;
  logic [WC_CNT_W-1:0] cnt_q, cnt_nxt, need;
  logic                flag_hi_q, flag_lo_q;
  logic [WC_THR_W-1:0] hys_ext, hi_rel, lo_rel, hi_lim, lo_lim;
  logic [WC_THR_W:0]   lo_sum;
  logic                hi_cond, lo_cond, in_band, hi_evt, lo_evt, viol, fire;

  assign hys_ext = WC_THR_W'(cfg_i.hys);
  assign hi_rel  = (hys_ext >= cfg_i.thr_hi) ? '0 : cfg_i.thr_hi - hys_ext;
  assign lo_sum  = {1'b0, cfg_i.thr_lo} + {1'b0, hys_ext};
  assign lo_rel  = lo_sum[WC_THR_W] ? ThrMax : lo_sum[WC_THR_W-1:0];

  // active condition holds until value crosses the relaxed limit
  assign hi_lim  = hi_act_q ? hi_rel : cfg_i.thr_hi;
  assign lo_lim  = lo_act_q ? lo_rel : cfg_i.thr_lo;
  assign hi_cond = data_i > hi_lim;
  assign lo_cond = data_i < lo_lim;
  assign in_band = !hi_cond && !lo_cond;

  assign hi_evt  = cfg_i.region ? in_band : hi_cond;
  assign lo_evt  = cfg_i.region ? in_band : lo_cond;
  assign viol    = hi_evt || lo_evt;

  always_comb begin
    if (!viol)              cnt_nxt = '0;
    else if (cnt_q == CntMax) cnt_nxt = cnt_q;
    else                    cnt_nxt = cnt_q + 1'b1;
  end

  assign need = (cfg_i.evt == '0) ? WC_CNT_W'(1) : cfg_i.evt;
  assign fire = viol && (cnt_nxt >= need);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_act_q <= 1'b0;
      lo_act_q <= 1'b0;
      cnt_q    <= '0;
    end else if (smp_i) begin
      hi_act_q <= hi_cond;
      lo_act_q <= lo_cond;
      cnt_q    <= cnt_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_hi_q <= 1'b0;
      flag_lo_q <= 1'b0;
    end else begin
      flag_hi_q <= (smp_i && fire && hi_evt) || (flag_hi_q && !clr_hi_i);
      flag_lo_q <= (smp_i && fire && lo_evt) || (flag_lo_q && !clr_lo_i);
    end
  end

  assign flag_hi_o = flag_hi_q;
  assign flag_lo_o = flag_lo_q;
endmodule

// File: rtl/win_cmp_top.sv
module win_cmp_top
  import wc_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned RES_W  = 16,
  parameter int unsigned CH_W   = $clog2(NUM_CH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_wr_i,
  input  logic [CH_W-1:0]     cfg_ch_i,
  input  logic [WC_THR_W-1:0] cfg_thr_hi_i,
  input  logic [WC_THR_W-1:0] cfg_thr_lo_i,
  input  logic [WC_HYS_W-1:0] cfg_hys_i,
  input  logic [WC_CNT_W-1:0] cfg_evt_i,
  input  logic                cfg_region_i,
  input  logic                cmp_en_i,
  input  logic                avg_i,
  input  logic                vld_i,
  input  logic [CH_W-1:0]     ch_i,
  input  logic [RES_W-1:0]    res_i,
  input  logic [NUM_CH-1:0]   alert_mask_i,
  input  logic [NUM_CH-1:0]   clr_hi_i,
  input  logic [NUM_CH-1:0]   clr_lo_i,
  output logic [NUM_CH-1:0]   flag_hi_o,
  output logic [NUM_CH-1:0]   flag_lo_o,
  output logic                alert_o
);
  chan_cfg_t                wdata;
  chan_cfg_t [NUM_CH-1:0]   cfg;
  logic [WC_THR_W-1:0]      data;

  assign wdata = '{
    thr_hi: cfg_thr_hi_i, thr_lo: cfg_thr_lo_i, hys: cfg_hys_i,
    evt: cfg_evt_i, region: cfg_region_i
  };

  wc_cfg_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_wr_i),
    .ch_i    (cfg_ch_i),
    .wdata_i (wdata),
    .cfg_o   (cfg)
  );

  // averaged codes are compared on their top bits
  assign data = avg_i ? res_i[RES_W-1 -: WC_THR_W] : res_i[WC_THR_W-1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    wc_chan u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .smp_i     (vld_i && cmp_en_i && ch_i == CH_W'(g)),
      .data_i    (data),
      .cfg_i     (cfg[g]),
      .clr_hi_i  (clr_hi_i[g]),
      .clr_lo_i  (clr_lo_i[g]),
      .flag_hi_o (flag_hi_o[g]),
      .flag_lo_o (flag_lo_o[g])
    );
  end

  assign alert_o = |((flag_hi_o | flag_lo_o) & alert_mask_i);
endmodule

// File: rtl/wc_checker.sv
module wc_checker #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CH_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              vld_i,
  input logic              cmp_en_i,
  input logic [CH_W-1:0]   ch_i,
  input logic [NUM_CH-1:0] alert_mask_i,
  input logic [NUM_CH-1:0] clr_hi_i,
  input logic [NUM_CH-1:0] clr_lo_i,
  input logic [NUM_CH-1:0] flag_hi_o,
  input logic [NUM_CH-1:0] flag_lo_o,
  input logic              alert_o
);
  AST_RESET_CLEAN: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (flag_hi_o == '0 && flag_lo_o == '0 && !alert_o)); // R1

  AST_ALERT_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o |-> (|alert_mask_i)); // R9

  AST_ALERT_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o |-> (|(flag_hi_o | flag_lo_o))); // R9

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    AST_HI_SET_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_hi_o[g]) |-> $past(vld_i && cmp_en_i && ch_i == CH_W'(g))); // R7

    AST_LO_SET_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_lo_o[g]) |-> $past(vld_i && cmp_en_i && ch_i == CH_W'(g))); // R10

    AST_HI_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flag_hi_o[g]) |-> $past(clr_hi_i[g])); // R8

    AST_LO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flag_lo_o[g]) |-> $past(clr_lo_i[g])); // R8
  end
endmodule

bind win_cmp_top wc_checker #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .vld_i        (vld_i),
  .cmp_en_i     (cmp_en_i),
  .ch_i         (ch_i),
  .alert_mask_i (alert_mask_i),
  .clr_hi_i     (clr_hi_i),
  .clr_lo_i     (clr_lo_i),
  .flag_hi_o    (flag_hi_o),
  .flag_lo_o    (flag_lo_o),
  .alert_o      (alert_o)
);

// File: tb/win_cmp_top_tb.sv
module win_cmp_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [2:0]  cfg_ch_i = '0;
  logic [11:0] cfg_thr_hi_i = '0;
  logic [11:0] cfg_thr_lo_i = '0;
  logic [7:0]  cfg_hys_i = '0;
  logic [3:0]  cfg_evt_i = '0;
  logic        cfg_region_i = 1'b0;
  logic        cmp_en_i = 1'b1;
  logic        avg_i = 1'b0;
  logic        vld_i = 1'b0;
  logic [2:0]  ch_i = '0;
  logic [15:0] res_i = '0;
  logic [7:0]  alert_mask_i = '0;
  logic [7:0]  clr_hi_i = '0;
  logic [7:0]  clr_lo_i = '0;
  logic [7:0]  flag_hi_o, flag_lo_o;
  logic        alert_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  win_cmp_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_wr_i(cfg_wr_i), .cfg_ch_i(cfg_ch_i),
    .cfg_thr_hi_i(cfg_thr_hi_i), .cfg_thr_lo_i(cfg_thr_lo_i), .cfg_hys_i(cfg_hys_i),
    .cfg_evt_i(cfg_evt_i), .cfg_region_i(cfg_region_i), .cmp_en_i(cmp_en_i),
    .avg_i(avg_i), .vld_i(vld_i), .ch_i(ch_i), .res_i(res_i),
    .alert_mask_i(alert_mask_i), .clr_hi_i(clr_hi_i), .clr_lo_i(clr_lo_i),
    .flag_hi_o(flag_hi_o), .flag_lo_o(flag_lo_o), .alert_o(alert_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i) rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic cfg(input int ch, input int hi, input int lo, input int hys,
                     input int evt, input bit region);
    @(negedge clk_i);
    cfg_wr_i = 1'b1; cfg_ch_i = 3'(ch); cfg_thr_hi_i = 12'(hi);
    cfg_thr_lo_i = 12'(lo); cfg_hys_i = 8'(hys); cfg_evt_i = 4'(evt);
    cfg_region_i = region;
    @(negedge clk_i) cfg_wr_i = 1'b0;
  endtask

  // one sample; returns at the falling edge after the capturing edge
  task automatic smp(input int ch, input int val);
    @(negedge clk_i);
    vld_i = 1'b1; ch_i = 3'(ch); res_i = 16'(val);
    @(negedge clk_i) vld_i = 1'b0;
  endtask

  task automatic clr_all();
    @(negedge clk_i) begin clr_hi_i = '1; clr_lo_i = '1; end
    @(negedge clk_i) begin clr_hi_i = '0; clr_lo_i = '0; end
  endtask

  task automatic chk_flags(input int ch, input bit eh, input bit el, input string req);
    chk(flag_hi_o[ch] == eh, {req, " hi"}, flag_hi_o[ch], eh);
    chk(flag_lo_o[ch] == el, {req, " lo"}, flag_lo_o[ch], el);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state and default limits
    chk(flag_hi_o == '0 && flag_lo_o == '0, "R1 flags at reset", {flag_hi_o, flag_lo_o}, 0);
    chk(alert_o == 1'b0, "R1 alert at reset", alert_o, 0);
    alert_mask_i = '1;
    for (int c = 0; c < 8; c++) begin
      smp(c, 12'hFFF); smp(c, 0); smp(c, 12'h7A5);
    end
    chk(flag_hi_o == '0 && flag_lo_o == '0, "R1 default limits", {flag_hi_o, flag_lo_o}, 0);
    chk(alert_o == 1'b0, "R1 default alert", alert_o, 0);
    alert_mask_i = '0;

    // R2/R10: full sweep, outside band on ch0
    cfg(0, 12'h800, 12'h400, 0, 0, 1'b0);
    for (int v = 0; v < 4096; v++) begin
      smp(0, v);
      chk_flags(0, v > 12'h800, v < 12'h400, "R2 sweep");
      chk(flag_hi_o[7:1] == '0 && flag_lo_o[7:1] == '0, "R10 isolation",
          {flag_hi_o[7:1], flag_lo_o[7:1]}, 0);
      clr_all();
    end

    // R3: full sweep, inside band on ch5
    cfg(5, 12'h900, 12'h300, 0, 0, 1'b1);
    for (int v = 0; v < 4096; v++) begin
      smp(5, v);
      chk_flags(5, v >= 12'h300 && v <= 12'h900, v >= 12'h300 && v <= 12'h900, "R3 sweep");
      clr_all();
    end

    // R4: hysteresis on both limits
    do_reset();
    cfg(2, 12'h800, 12'h100, 8'h10, 0, 1'b0);
    smp(2, 12'h801); chk_flags(2, 1, 0, "R4 hi enter"); clr_all();
    smp(2, 12'h7F5); chk_flags(2, 1, 0, "R4 hi hold"); clr_all();
    smp(2, 12'h7F0); chk_flags(2, 0, 0, "R4 hi release"); clr_all();
    smp(2, 12'h7F5); chk_flags(2, 0, 0, "R4 hi rearm"); clr_all();
    smp(2, 12'h0FF); chk_flags(2, 0, 1, "R4 lo enter"); clr_all();
    smp(2, 12'h10F); chk_flags(2, 0, 1, "R4 lo hold"); clr_all();
    smp(2, 12'h110); chk_flags(2, 0, 0, "R4 lo release"); clr_all();
    smp(2, 12'h10F); chk_flags(2, 0, 0, "R4 lo rearm"); clr_all();
    // R4: saturation of relaxed limits
    cfg(6, 12'h008, 12'hFF8, 8'h20, 0, 1'b0);
    smp(6, 12'h009); chk_flags(6, 1, 1, "R4 sat enter"); clr_all();
    smp(6, 12'h001); chk_flags(6, 1, 1, "R4 sat hold"); clr_all();

    // R5: consecutive-run qualification
    cfg(3, 12'h800, 0, 0, 3, 1'b0);
    smp(3, 12'h900); smp(3, 12'h900); chk_flags(3, 0, 0, "R5 run of two");
    smp(3, 12'h500); smp(3, 12'h900); smp(3, 12'h900);
    chk_flags(3, 0, 0, "R5 restart after good");
    smp(3, 12'h900); chk_flags(3, 1, 0, "R5 third in a row");

    // R6: compared bit slice
    do_reset();
    cfg(4, 12'h800, 0, 0, 0, 1'b0);
    avg_i = 1'b1; smp(4, 16'h8010); chk_flags(4, 1, 0, "R6 avg upper"); clr_all();
    avg_i = 1'b0; smp(4, 16'h8010); chk_flags(4, 0, 0, "R6 plain ignores upper"); clr_all();
    smp(4, 16'h0801); chk_flags(4, 1, 0, "R6 plain lower"); clr_all();
    avg_i = 1'b1; smp(4, 16'h0801); chk_flags(4, 0, 0, "R6 avg ignores lower"); clr_all();
    avg_i = 1'b0;

    // R7: disabled samples leave no trace
    cfg(1, 12'h800, 0, 0, 2, 1'b0);
    cmp_en_i = 1'b0;
    smp(1, 12'hA00); smp(1, 12'hA00);
    chk_flags(1, 0, 0, "R7 disabled");
    cmp_en_i = 1'b1;
    smp(1, 12'hA00); chk_flags(1, 0, 0, "R7 count untouched");
    smp(1, 12'hA00); chk_flags(1, 1, 0, "R7 counting resumes");

    // R8: sticky, per-bit clear, set wins
    smp(1, 12'h100); chk_flags(1, 1, 0, "R8 sticky");
    @(negedge clk_i) clr_lo_i[1] = 1'b1;
    @(negedge clk_i) clr_lo_i[1] = 1'b0;
    chk_flags(1, 1, 0, "R8 other bit kept");
    @(negedge clk_i) clr_hi_i[1] = 1'b1;
    @(negedge clk_i) clr_hi_i[1] = 1'b0;
    chk_flags(1, 0, 0, "R8 cleared");
    smp(1, 12'hA00); smp(1, 12'hA00);
    @(negedge clk_i) begin vld_i = 1'b1; ch_i = 3'd1; res_i = 16'hA00; clr_hi_i[1] = 1'b1; end
    @(negedge clk_i) begin vld_i = 1'b0; clr_hi_i[1] = 1'b0; end
    chk_flags(1, 1, 0, "R8 set wins");

    // R9: mask gates only the alert
    alert_mask_i = 8'h00;
    @(negedge clk_i);
    chk(alert_o == 1'b0, "R9 masked", alert_o, 0);
    chk(flag_hi_o[1] == 1'b1, "R9 flag kept while masked", flag_hi_o[1], 1);
    alert_mask_i = 8'hFD;
    @(negedge clk_i);
    chk(alert_o == 1'b0, "R9 other channels", alert_o, 0);
    alert_mask_i = 8'h02;
    @(negedge clk_i);
    chk(alert_o == 1'b1, "R9 enabled", alert_o, 1);
    clr_all();
    chk(alert_o == 1'b0, "R9 after clear", alert_o, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule